// File: doc/BRIEF.md
# Cascadable Gated Prescaled Timer

This block holds two 16-bit up-counters, A and B. Each counter has its own control, count and period register on a small synchronous register bus. Each counter takes count events from one of two sources. The first is the system clock, which gives one event per cycle. The second is an external input, which is synchronized and counted on its rising edges. The events pass through a selectable prescaler before they reach the counter.

A gated mode counts system-clock events only while a gate input is high. When the gate falls, a gate-done flag is set. An idle-stop option freezes a counter while an idle request is asserted. When a counter reaches its period value, it wraps to zero and sets a sticky match flag.

A wide-mode bit in timer A's control register joins the two counters into one 32-bit timer. In that mode timer A supplies the low word and drives the whole timer. Timer B's control register has no effect on the joined timer.

Top module: `tmr_pair`

## Requirements
- R1: After reset, both control registers, both counters and the flag register read 0, and both period registers read 0xFFFF. Read data is registered: `bus_rdata` shows the register selected by `bus_addr` one clock later.
- R2: A control register stores only bit 15 (run), bit 13 (idle stop), bit 6 (gate), bits 5:4 (prescale), bit 3 (wide) and bit 1 (external source). Every other bit always reads 0, so writing 0xFFFF reads back as 0xA07A.
- R3: A counter advances only while its run bit is 1. After the run bit is cleared, the counter holds its value, and it never steps by more than one count per cycle.
- R4: Prescale code 00 advances the counter once per source event, 01 once per 8 events, 10 once per 64 events and 11 once per 256 events.
- R5: Any write to a timer's control register clears that timer's prescaler, so events gathered before the write are discarded.
- R6: With bit 1 set, the counter counts rising edges of its external input after a two-flop synchronizer, and it ignores the system clock. The gate bit has no effect in this mode.
- R7: With bit 6 set and bit 1 clear, the counter counts system-clock cycles only while its gate input is high. A falling edge of the gate sets the gate-done flag: flag bit 2 for timer A and flag bit 3 for timer B.
- R8: With bit 13 set, the counter halts while `idle_req` is high. With bit 13 clear, the counter keeps counting while `idle_req` is high.
- R9: On a count where the counter equals its period register, the counter becomes 0 and a sticky match flag is set. The match flag is flag bit 0 for A and flag bit 1 for B, and it also appears on `match_a` and `match_b`.
- R10: Writing 1 to a flag bit clears it. If a match or gate fall sets that flag in the same cycle, the set wins.
- R11: With the wide bit set in timer A's control register, {B,A} counts as one 32-bit counter clocked by timer A's settings. It is compared against {period B, period A}, and a match sets flag bit 0 only. Timer B's control register has no effect in this mode.
- R12: Register addresses are 0 control A, 1 count A, 2 period A, 3 control B, 4 count B, 5 period B, 6 flags. A count write loads the counter and takes priority over a count in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the internal count source |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| tck_a | input | 1 | External count input, timer A |
| tck_b | input | 1 | External count input, timer B |
| gate_a | input | 1 | Gate input, timer A |
| gate_b | input | 1 | Gate input, timer B |
| idle_req | input | 1 | Idle request |
| match_a | output | 1 | Sticky match flag, timer A or joined timer |
| match_b | output | 1 | Sticky match flag, timer B |
| gdone_a | output | 1 | Sticky gate-done flag, timer A |
| gdone_b | output | 1 | Sticky gate-done flag, timer B |

## Verification
A period match and a software clear of the same match flag can land in the same clock edge. The bench sets the period to 3 and starts the counter. It then times a write-one-to-clear of the flag register so that the write is captured on the fourth count, which is exactly the edge where the counter wraps. A read-back must still show the flag set. A second clear, issued while the counter is stopped, must then empty the flag.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CW = 16;

  localparam int B_RUN  = 15;
  localparam int B_IDLE = 13;
  localparam int B_GATE = 6;
  localparam int B_PSH  = 5;
  localparam int B_PSL  = 4;
  localparam int B_WIDE = 3;
  localparam int B_EXT  = 1;

  localparam logic [CW-1:0] CTRL_MASK = 16'hA07A;

  typedef enum logic [2:0] {
    A_CTRL_A = 3'd0,
    A_CNT_A  = 3'd1,
    A_PER_A  = 3'd2,
    A_CTRL_B = 3'd3,
    A_CNT_B  = 3'd4,
    A_PER_B  = 3'd5,
    A_FLAG   = 3'd6
  } addr_e;

  typedef struct packed {
    logic       run;
    logic       idle_stop;
    logic       gated;
    logic [1:0] ps;
    logic       wide;
    logic       ext;
  } ctrl_t;

  function automatic ctrl_t decode_ctrl(input logic [CW-1:0] r);
    ctrl_t c;
    c.run       = r[B_RUN];
    c.idle_stop = r[B_IDLE];
    c.gated     = r[B_GATE];
    c.ps        = r[B_PSH:B_PSL];
    c.wide      = r[B_WIDE];
    c.ext       = r[B_EXT];
    return c;
  endfunction

  function automatic int unsigned ps_limit(input logic [1:0] sel);
    case (sel)
      2'b00:   return 0;
      2'b01:   return 7;
      2'b10:   return 63;
      default: return 255;
    endcase
  endfunction
endpackage

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sh;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      prev <= 1'b0;
    end else begin
      sh   <= {sh[STAGES-2:0], d};
      prev <= sh[STAGES-1];
    end
  end

  assign q    = sh[STAGES-1];
  assign rise = q & ~prev;
  assign fall = ~q & prev;
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale import tmr_pkg::*; #(
  parameter int PW = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       en,
  input  logic [1:0] sel,
  output logic       tick
);
  logic [PW-1:0] acc;
  logic [PW-1:0] lim;

  assign lim  = PW'(ps_limit(sel));
  assign tick = en & (acc == lim);

  always_ff @(posedge clk) begin
    if (rst || clr)
      acc <= '0;
    else if (en)
      acc <= tick ? '0 : acc + 1'b1;
  end
endmodule

// File: rtl/tmr_lane.sv
module tmr_lane import tmr_pkg::*; #(
  parameter int SYNC_STAGES = 2,
  parameter int PS_BITS     = 8
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  ext_in,
  input  logic  gate_in,
  input  ctrl_t cfg,
  input  logic  run,
  input  logic  ctrl_wr,
  output logic  tick,
  output logic  gate_fall
);
  logic ext_q, ext_rise, ext_fall;
  logic gate_q, gate_rise, gate_fell;
  logic event_in;

  tmr_sync_edge #(.STAGES(SYNC_STAGES)) u_ext (
    .clk(clk), .rst(rst), .d(ext_in),
    .q(ext_q), .rise(ext_rise), .fall(ext_fall)
  );

  tmr_sync_edge #(.STAGES(SYNC_STAGES)) u_gate (
    .clk(clk), .rst(rst), .d(gate_in),
    .q(gate_q), .rise(gate_rise), .fall(gate_fell)
  );

  // external edges, or system clock optionally qualified by the gate
  always_comb begin
    if (cfg.ext)        event_in = ext_rise;
    else if (cfg.gated) event_in = gate_q;
    else                event_in = 1'b1;
  end

  tmr_prescale #(.PW(PS_BITS)) u_ps (
    .clk(clk), .rst(rst), .clr(ctrl_wr),
    .en(run & event_in), .sel(cfg.ps), .tick(tick)
  );

  assign gate_fall = gate_fell & cfg.gated & ~cfg.ext;
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair import tmr_pkg::*; #(
  parameter int SYNC_STAGES = 2,
  parameter int PS_BITS     = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_we,
  input  logic [2:0]    bus_addr,
  input  logic [CW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata,
  input  logic          tck_a,
  input  logic          tck_b,
  input  logic          gate_a,
  input  logic          gate_b,
  input  logic          idle_req,
  output logic          match_a,
  output logic          match_b,
  output logic          gdone_a,
  output logic          gdone_b
);
  localparam int NL = 2;
  localparam int WW = NL * CW;

  logic [CW-1:0] ctrl_q [NL];
  logic [CW-1:0] cnt_q  [NL];
  logic [CW-1:0] per_q  [NL];
  ctrl_t         cfg    [NL];
  logic [NL-1:0] run, tick, gfall, ctrl_wr, cnt_wr, per_wr;
  logic [NL-1:0] ext_in, gate_in;
  logic [NL-1:0] hit;
  logic [NL-1:0] match_q, gdone_q;
  logic          flag_wr;
  logic          wide;
  logic [WW-1:0] wide_cnt, wide_per;
  logic          wide_hit;

  assign ext_in  = {tck_b, tck_a};
  assign gate_in = {gate_b, gate_a};
  assign flag_wr = bus_we && (bus_addr == A_FLAG);

  for (genvar i = 0; i < NL; i++) begin : g_lane
    assign cfg[i]     = decode_ctrl(ctrl_q[i]);
    assign ctrl_wr[i] = bus_we && (bus_addr == 3'(3 * i));
    assign cnt_wr[i]  = bus_we && (bus_addr == 3'(3 * i + 1));
    assign per_wr[i]  = bus_we && (bus_addr == 3'(3 * i + 2));
    assign run[i]     = cfg[i].run & ~(cfg[i].idle_stop & idle_req);

    tmr_lane #(.SYNC_STAGES(SYNC_STAGES), .PS_BITS(PS_BITS)) u_lane (
      .clk(clk), .rst(rst),
      .ext_in(ext_in[i]), .gate_in(gate_in[i]),
      .cfg(cfg[i]), .run(run[i]), .ctrl_wr(ctrl_wr[i]),
      .tick(tick[i]), .gate_fall(gfall[i])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        ctrl_q[i] <= '0;
        per_q[i]  <= '1;
      end else begin
        if (ctrl_wr[i]) ctrl_q[i] <= bus_wdata & CTRL_MASK;
        if (per_wr[i])  per_q[i]  <= bus_wdata;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        match_q[i] <= 1'b0;
        gdone_q[i] <= 1'b0;
      end else begin
        match_q[i] <= (match_q[i] & ~(flag_wr & bus_wdata[i]))      | hit[i];
        gdone_q[i] <= (gdone_q[i] & ~(flag_wr & bus_wdata[NL + i])) | gfall[i];
      end
    end
  end

  // joined 32-bit view; timer A's settings drive it
  assign wide     = cfg[0].wide;
  assign wide_cnt = {cnt_q[1], cnt_q[0]};
  assign wide_per = {per_q[1], per_q[0]};
  assign wide_hit = (wide_cnt == wide_per);

  assign hit[0] = tick[0] & (wide ? wide_hit : (cnt_q[0] == per_q[0]));
  assign hit[1] = ~wide & tick[1] & (cnt_q[1] == per_q[1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q[0] <= '0;
      cnt_q[1] <= '0;
    end else begin
      if (cnt_wr[0])    cnt_q[0] <= bus_wdata;
      else if (tick[0]) cnt_q[0] <= hit[0] ? '0 : cnt_q[0] + 1'b1;

      if (cnt_wr[1]) begin
        cnt_q[1] <= bus_wdata;
      end else if (wide) begin
        if (tick[0])
          cnt_q[1] <= wide_hit ? '0 : cnt_q[1] + CW'(&cnt_q[0]);
      end else if (tick[1]) begin
        cnt_q[1] <= hit[1] ? '0 : cnt_q[1] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (addr_e'(bus_addr))
        A_CTRL_A: bus_rdata <= ctrl_q[0];
        A_CNT_A:  bus_rdata <= cnt_q[0];
        A_PER_A:  bus_rdata <= per_q[0];
        A_CTRL_B: bus_rdata <= ctrl_q[1];
        A_CNT_B:  bus_rdata <= cnt_q[1];
        A_PER_B:  bus_rdata <= per_q[1];
        A_FLAG:   bus_rdata <= CW'({gdone_q, match_q});
        default:  bus_rdata <= '0;
      endcase
    end
  end

  assign match_a = match_q[0];
  assign match_b = match_q[1];
  assign gdone_a = gdone_q[0];
  assign gdone_b = gdone_q[1];
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk import tmr_pkg::*; (
  input logic          clk,
  input logic          rst,
  input logic          bus_we,
  input logic [2:0]    bus_addr,
  input logic [CW-1:0] bus_wdata,
  input logic [CW-1:0] bus_rdata,
  input logic          idle_req,
  input logic [CW-1:0] ctrl_a,
  input logic [CW-1:0] cnt_a,
  input logic          match_a
);
  logic cnt_wr;
  assign cnt_wr = bus_we && (bus_addr == A_CNT_A);

  a_r2_unimpl_zero: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_addr) == A_CTRL_A) |-> ((bus_rdata & ~CTRL_MASK) == '0));

  a_r3_halt_when_off: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_a[B_RUN] && !cnt_wr) |=> $stable(cnt_a));

  a_r3_single_step: assert property (@(posedge clk) disable iff (rst)
    (!cnt_wr) |=> (cnt_a == $past(cnt_a) || cnt_a == $past(cnt_a) + 16'd1 || cnt_a == '0));

  a_r8_idle_freeze: assert property (@(posedge clk) disable iff (rst)
    (ctrl_a[B_RUN] && ctrl_a[B_IDLE] && idle_req && !cnt_wr) |=> $stable(cnt_a));

  a_r9_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
    ($rose(match_a) && !$past(cnt_wr)) |-> (cnt_a == '0));

  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (match_a && !(bus_we && bus_addr == A_FLAG && bus_wdata[0])) |=> match_a);
endmodule

bind tmr_pair tmr_pair_chk u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .idle_req(idle_req),
  .ctrl_a(ctrl_q[0]), .cnt_a(cnt_q[0]), .match_a(match_a)
);

// File: tb/sim_tmr_pair.sv
`timescale 1ns/1ps
module sim_tmr_pair;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic        tck_a = 1'b0, tck_b = 1'b0, gate_a = 1'b0, gate_b = 1'b0, idle_req = 1'b0;
  logic        match_a, match_b, gdone_a, gdone_b;
  int          checks = 0;
  int          errors = 0;

  always #2 clk = ~clk;

  tmr_pair u0 (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tck_a(tck_a), .tck_b(tck_b), .gate_a(gate_a), .gate_b(gate_b),
    .idle_req(idle_req), .match_a(match_a), .match_b(match_b),
    .gdone_a(gdone_a), .gdone_b(gdone_b)
  );

  task automatic chk(input string req, input string what, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %04h expected %04h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  // start at a negedge, let n-1 further cycles pass, stop: n counts at 1:1
  task automatic run_for(input logic [2:0] ca, input logic [15:0] cv, input int n);
    wr(ca, cv);
    repeat (n - 1) @(negedge clk);
    wr(ca, cv & 16'h7FFF);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rd(3'd0, v); chk("R1", "ctrl A", v, 16'h0000);
    rd(3'd1, v); chk("R1", "count A", v, 16'h0000);
    rd(3'd2, v); chk("R1", "period A", v, 16'hFFFF);
    rd(3'd5, v); chk("R1", "period B", v, 16'hFFFF);
    rd(3'd6, v); chk("R1", "flags", v, 16'h0000);
  endtask

  task automatic t_ctrl_mask;
    logic [15:0] v;
    wr(3'd3, 16'hFFFF);
    rd(3'd3, v); chk("R2", "ctrl B readback", v, 16'hA07A);
    wr(3'd3, 16'h0000);
    wr(3'd5, 16'h1234);
    rd(3'd5, v); chk("R12", "period B readback", v, 16'h1234);
    wr(3'd5, 16'hFFFF);
  endtask

  task automatic t_run_stop;
    logic [15:0] v;
    wr(3'd1, 16'd0);
    run_for(3'd0, 16'h8000, 10);
    rd(3'd1, v); chk("R3", "count after 10 cycles", v, 16'd10);
    repeat (5) @(negedge clk);
    rd(3'd1, v); chk("R3", "count held when stopped", v, 16'd10);
    wr(3'd1, 16'h0042);
    rd(3'd1, v); chk("R12", "count write", v, 16'h0042);
  endtask

  task automatic t_prescale;
    logic [15:0] v;
    wr(3'd1, 16'd0); run_for(3'd0, 16'h8010, 20);
    rd(3'd1, v); chk("R4", "1:8 after 20 events", v, 16'd2);
    wr(3'd1, 16'd0); run_for(3'd0, 16'h8020, 130);
    rd(3'd1, v); chk("R4", "1:64 after 130 events", v, 16'd2);
    wr(3'd1, 16'd0); run_for(3'd0, 16'h8030, 520);
    rd(3'd1, v); chk("R4", "1:256 after 520 events", v, 16'd2);
  endtask

  task automatic t_ps_clear;
    logic [15:0] v;
    wr(3'd1, 16'd0);
    run_for(3'd0, 16'h8010, 5);
    run_for(3'd0, 16'h8010, 5);
    rd(3'd1, v); chk("R5", "prescaler cleared by ctrl write", v, 16'd0);
  endtask

  task automatic t_ext;
    logic [15:0] v;
    wr(3'd1, 16'd0);
    wr(3'd0, 16'h8042);
    for (int k = 0; k < 6; k++) begin
      tck_a = 1'b1; repeat (3) @(negedge clk);
      tck_a = 1'b0; repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    wr(3'd0, 16'h0000);
    rd(3'd1, v); chk("R6", "external edges counted, gate ignored", v, 16'd6);
  endtask

  task automatic t_gated;
    logic [15:0] v;
    wr(3'd6, 16'h000F);
    wr(3'd1, 16'd0);
    wr(3'd0, 16'h8040);
    repeat (5) @(negedge clk);
    gate_a = 1'b1; repeat (12) @(negedge clk);
    gate_a = 1'b0; repeat (8) @(negedge clk);
    wr(3'd0, 16'h0000);
    rd(3'd1, v); chk("R7", "gated count", v, 16'd12);
    rd(3'd6, v); chk("R7", "gate-done flag bit 2", v & 16'h0004, 16'h0004);
    chk("R7", "gdone_a port", {15'd0, gdone_a}, 16'd1);
    wr(3'd6, 16'h0004);
    rd(3'd6, v); chk("R10", "gate-done cleared", v & 16'h0004, 16'h0000);
  endtask

  task automatic t_idle;
    logic [15:0] v;
    idle_req = 1'b1;
    wr(3'd1, 16'd0);
    run_for(3'd0, 16'hA000, 10);
    rd(3'd1, v); chk("R8", "frozen while idle", v, 16'd0);
    run_for(3'd0, 16'h8000, 10);
    rd(3'd1, v); chk("R8", "runs through idle", v, 16'd10);
    idle_req = 1'b0;
  endtask

  task automatic t_match;
    logic [15:0] v;
    wr(3'd6, 16'h000F);
    wr(3'd2, 16'd4);
    wr(3'd1, 16'd0);
    run_for(3'd0, 16'h8000, 7);
    rd(3'd1, v); chk("R9", "wrapped count", v, 16'd2);
    rd(3'd6, v); chk("R9", "match flag bit 0", v & 16'h0003, 16'h0001);
    chk("R9", "match_a port", {15'd0, match_a}, 16'd1);
  endtask

  task automatic t_w1c_collide;
    logic [15:0] v;
    wr(3'd6, 16'h000F);
    wr(3'd2, 16'd3);
    wr(3'd1, 16'd0);
    wr(3'd0, 16'h8000);
    repeat (3) @(negedge clk);
    wr(3'd6, 16'h0001);
    wr(3'd0, 16'h0000);
    rd(3'd1, v); chk("R10", "count after 5 ticks", v, 16'd1);
    rd(3'd6, v); chk("R10", "set wins over clear", v & 16'h0001, 16'h0001);
    wr(3'd6, 16'h0001);
    rd(3'd6, v); chk("R10", "clear alone", v & 16'h0001, 16'h0000);
  endtask

  task automatic t_lane_b;
    logic [15:0] v;
    wr(3'd0, 16'h0000); wr(3'd1, 16'd0);
    wr(3'd5, 16'd2); wr(3'd4, 16'd0);
    run_for(3'd3, 16'h8000, 5);
    rd(3'd4, v); chk("R9", "timer B wrapped", v, 16'd2);
    chk("R9", "match_b port", {15'd0, match_b}, 16'd1);
    rd(3'd1, v); chk("R3", "timer A untouched", v, 16'd0);
    wr(3'd6, 16'h000F);
  endtask

  task automatic t_wide;
    logic [15:0] v;
    wr(3'd3, 16'h8030);
    wr(3'd1, 16'hFFFE); wr(3'd4, 16'd0);
    wr(3'd2, 16'd1);    wr(3'd5, 16'd1);
    run_for(3'd0, 16'h8008, 2);
    rd(3'd1, v); chk("R11", "low word after carry", v, 16'h0000);
    rd(3'd4, v); chk("R11", "high word after carry", v, 16'h0001);
    run_for(3'd0, 16'h8008, 2);
    rd(3'd1, v); chk("R11", "low word after 32-bit wrap", v, 16'h0000);
    rd(3'd4, v); chk("R11", "high word after 32-bit wrap", v, 16'h0000);
    rd(3'd6, v); chk("R11", "flag bits after 32-bit match", v & 16'h0003, 16'h0001);
    wr(3'd3, 16'h0000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ctrl_mask();
    t_run_stop();
    t_prescale();
    t_ps_clear();
    t_ext();
    t_gated();
    t_idle();
    t_match();
    t_w1c_collide();
    t_lane_b();
    t_wide();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule